// File: doc/BRIEF.md
# Instruction Decoder with Branch Target Adder

This block is the purely combinational decode stage of a 32-bit RISC core whose instructions are all one word wide. It takes the instruction word and the address it was fetched from. From the word it extracts the two source register numbers, the destination register number and a sign-extended 16-bit immediate. It classifies the operation as one of five classes: register ALU operation, load-immediate, load word, store word, or branch-if-equal. From that class it drives the control signals that the execute, memory and write-back stages use.

The block also computes the taken-branch address for every word, whether or not the word is a branch. The branch offset counts instructions relative to the following instruction. Any opcode outside the five classes becomes a harmless no-operation, with every enable low. So does a register ALU word whose function code is not one of the nine defined ones. Register storage, hazard handling and memory access live in other blocks.

Top module: `insn_decode`

## Requirements
- R1: `rs1_o` always equals instruction bits 25:21 and `rs2_o` always equals bits 20:16, for every opcode.
- R2: Opcode 000000 with a function code (bits 3:0) of 0000, 0010, 0100, 0101, 1010, 1011, 1100, 1110 or 1111 decodes as follows. `reg_we_o` is 1, `rd_o` is bits 15:11 and `alu_fn_o` is bits 3:0. `alu_src_imm_o`, `mem_re_o`, `mem_we_o`, `branch_o` and `wb_mem_o` are all 0. Bits 10:4 have no effect.
- R3: Opcode 000000 with any other function code decodes as a no-operation, exactly as in R10.
- R4: Opcode 000011 (load-immediate) sets `reg_we_o`=1 and `alu_src_imm_o`=1, with `rd_o` = bits 20:16 and `alu_fn_o`=0000 (add). The memory enables, `branch_o` and `wb_mem_o` are all 0.
- R5: Opcode 100011 (load word) sets `reg_we_o`=1, `alu_src_imm_o`=1, `mem_re_o`=1 and `wb_mem_o`=1, with `rd_o` = bits 20:16 and `alu_fn_o`=0000. `mem_we_o` and `branch_o` are 0.
- R6: Opcode 101011 (store word) sets `mem_we_o`=1 and `alu_src_imm_o`=1, with `alu_fn_o`=0000. `reg_we_o`, `mem_re_o`, `branch_o` and `wb_mem_o` are 0, and `rd_o` is 0.
- R7: Opcode 000100 (branch-if-equal) sets `branch_o`=1 and `alu_fn_o`=0010 (subtract, used for the compare), with `alu_src_imm_o`=0. All write and memory enables are 0, and `rd_o` is 0.
- R8: `imm_o` is bits 15:0 sign-extended to 32 bits, for every opcode.
- R9: `br_target_o` = `pc_i` + 4 + 4 × sign-extended bits 15:0, modulo 2^32, for every word. An offset of −1 gives `pc_i`.
- R10: Any opcode other than the five above gives a no-operation. All of `reg_we_o`, `alu_src_imm_o`, `mem_re_o`, `mem_we_o`, `branch_o` and `wb_mem_o` are 0, and `rd_o` and `alu_fn_o` are 0.
- R11: `mem_re_o` and `mem_we_o` are never both 1, and `reg_we_o` is never 1 together with `mem_we_o` or `branch_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being decoded |
| pc_i | input | 32 | Byte address the instruction was fetched from |
| rs1_o | output | 5 | First source register number |
| rs2_o | output | 5 | Second source register number |
| rd_o | output | 5 | Destination register number (0 when nothing is written) |
| imm_o | output | 32 | Sign-extended immediate or offset |
| alu_fn_o | output | 4 | ALU operation code |
| alu_src_imm_o | output | 1 | ALU second operand comes from the immediate |
| reg_we_o | output | 1 | Register file write enable |
| mem_re_o | output | 1 | Data memory read |
| mem_we_o | output | 1 | Data memory write |
| branch_o | output | 1 | Instruction is a conditional branch |
| wb_mem_o | output | 1 | Write-back value comes from memory rather than the ALU |
| br_target_o | output | 32 | Taken-branch address |

## Verification
Every one of the nine ALU function codes is applied with distinct register numbers. This shows that each code passes through unchanged and that the destination comes from bits 15:11 rather than 20:16. One word also sets the reserved bits 10:4 to show they have no effect, and two undefined function codes separate a legal ALU word from the no-operation fallback. The three immediate-form classes use differing immediates with the sign bit both set and clear, which separates sign extension from zero extension and routes the destination from bits 20:16. Branch words with offsets −1, +32767 and −32768, plus wrap-around at the top of the address space, separate the following-instruction base and word scaling from a plain byte offset, and a sweep over all 64 opcodes confirms the fallback and the enable exclusivity.

// File: rtl/idec_pkg.sv
package idec_pkg;

    localparam int OPC_W = 6;
    localparam int FN_W  = 4;
    localparam int RA_W  = 5;
    localparam int IMM_W = 16;

    localparam logic [OPC_W-1:0] OPC_ALU = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LDI = 6'b000011;
    localparam logic [OPC_W-1:0] OPC_BEQ = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_LDW = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STW = 6'b101011;

    localparam logic [FN_W-1:0] FN_ADD  = 4'b0000;
    localparam logic [FN_W-1:0] FN_SUB  = 4'b0010;
    localparam logic [FN_W-1:0] FN_AND  = 4'b0100;
    localparam logic [FN_W-1:0] FN_OR   = 4'b0101;
    localparam logic [FN_W-1:0] FN_NOR  = 4'b1010;
    localparam logic [FN_W-1:0] FN_NAND = 4'b1011;
    localparam logic [FN_W-1:0] FN_SHL  = 4'b1100;
    localparam logic [FN_W-1:0] FN_SRL  = 4'b1110;
    localparam logic [FN_W-1:0] FN_SRA  = 4'b1111;

    typedef struct packed {
        logic            reg_we;
        logic            dst_itype;
        logic            src_imm;
        logic [FN_W-1:0] alu_fn;
        logic            mem_re;
        logic            mem_we;
        logic            branch;
        logic            wb_mem;
    } ctrl_t;

    localparam ctrl_t CTRL_NOP = '0;

endpackage

// File: rtl/idec_fields.sv
module idec_fields
    import idec_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]       instr_i,
    output logic [OPC_W-1:0]  opc_o,
    output logic [FN_W-1:0]   fn_o,
    output logic [RA_W-1:0]   rs1_o,
    output logic [RA_W-1:0]   rs2_o,
    output logic [RA_W-1:0]   rd_r_o,
    output logic [RA_W-1:0]   rd_i_o,
    output logic [XLEN-1:0]   imm_o
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_d;
    logic            unused_rsvd;

    assign opc_o  = instr_i[31:26];
    assign rs1_o  = instr_i[25:21];
    assign rs2_o  = instr_i[20:16];
    assign rd_i_o = instr_i[20:16];
    assign rd_r_o = instr_i[15:11];
    assign fn_o   = instr_i[3:0];
    assign unused_rsvd = ^instr_i[10:4];

    always_comb begin
        imm_d = {{EXT_W{instr_i[IMM_W-1]}}, instr_i[IMM_W-1:0]};
    end
    assign imm_o = imm_d;

    // R8: the bits above the immediate field copy its sign bit
    always_comb begin
        if (!$isunknown(instr_i)) begin
            p_sext_r8: assert (imm_o[XLEN-1:IMM_W] == {EXT_W{instr_i[15]}}
                               && imm_o[IMM_W-1:0] == instr_i[15:0])
                else $error("imm_o not sign extension of instruction bits 15:0");
        end
    end

endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
    import idec_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    input  logic [FN_W-1:0]  fn_i,
    output ctrl_t            ctrl_o
);
    ctrl_t ctrl_d;
    logic  fn_legal_d;

    always_comb begin
        unique case (fn_i)
            FN_ADD, FN_SUB, FN_AND, FN_OR, FN_NOR,
            FN_NAND, FN_SHL, FN_SRL, FN_SRA: fn_legal_d = 1'b1;
            default:                         fn_legal_d = 1'b0;
        endcase
    end

    always_comb begin
        ctrl_d = CTRL_NOP;
        case (opc_i)
            OPC_ALU: begin
                if (fn_legal_d) begin
                    ctrl_d.reg_we = 1'b1;
                    ctrl_d.alu_fn = fn_i;
                end
            end
            OPC_LDI: begin
                ctrl_d.reg_we    = 1'b1;
                ctrl_d.dst_itype = 1'b1;
                ctrl_d.src_imm   = 1'b1;
                ctrl_d.alu_fn    = FN_ADD;
            end
            OPC_LDW: begin
                ctrl_d.reg_we    = 1'b1;
                ctrl_d.dst_itype = 1'b1;
                ctrl_d.src_imm   = 1'b1;
                ctrl_d.alu_fn    = FN_ADD;
                ctrl_d.mem_re    = 1'b1;
                ctrl_d.wb_mem    = 1'b1;
            end
            OPC_STW: begin
                ctrl_d.src_imm   = 1'b1;
                ctrl_d.alu_fn    = FN_ADD;
                ctrl_d.mem_we    = 1'b1;
            end
            OPC_BEQ: begin
                ctrl_d.alu_fn    = FN_SUB;
                ctrl_d.branch    = 1'b1;
            end
            default: ctrl_d = CTRL_NOP;
        endcase
    end

    assign ctrl_o = ctrl_d;

    always_comb begin
        if (!$isunknown({opc_i, fn_i})) begin
            // R11
            p_mem_excl_r11: assert (!(ctrl_o.mem_re && ctrl_o.mem_we))
                else $error("memory read and write both asserted");
            // R11
            p_no_wr_r11: assert (!(ctrl_o.reg_we && (ctrl_o.mem_we || ctrl_o.branch)))
                else $error("register write with store or branch");
            // R5: memory write-back only for a load
            p_wb_load_r5: assert (ctrl_o.wb_mem == ctrl_o.mem_re)
                else $error("write-back source disagrees with memory read");
            // R10: an idle control word carries no ALU code
            p_nop_fn_r10: assert (ctrl_o.reg_we || ctrl_o.mem_we || ctrl_o.branch
                                  || ctrl_o.alu_fn == FN_ADD)
                else $error("no-operation with nonzero ALU code");
        end
    end

endmodule

// File: rtl/idec_target.sv
module idec_target #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] off_i,
    output logic [XLEN-1:0] tgt_o
);
    localparam int              SH    = $clog2(INSN_BYTES);
    localparam logic [XLEN-1:0] STEP  = XLEN'(INSN_BYTES);
    localparam logic [XLEN-1:0] LOMSK = XLEN'(INSN_BYTES - 1);

    logic [XLEN-1:0] next_pc_d;
    logic [XLEN-1:0] disp_d;
    logic [XLEN-1:0] tgt_d;

    always_comb begin
        next_pc_d = pc_i + STEP;
        disp_d    = off_i << SH;
        tgt_d     = next_pc_d + disp_d;
    end

    assign tgt_o = tgt_d;

    // R9: scaling by the instruction size keeps the byte lane of the PC
    always_comb begin
        if (!$isunknown({pc_i, off_i})) begin
            p_align_r9: assert (((tgt_o ^ pc_i) & LOMSK) == '0)
                else $error("branch target changed sub-word address bits");
        end
    end

endmodule

// File: rtl/insn_decode.sv
module insn_decode
    import idec_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [31:0]      instr_i,
    input  logic [XLEN-1:0]  pc_i,
    output logic [4:0]       rs1_o,
    output logic [4:0]       rs2_o,
    output logic [4:0]       rd_o,
    output logic [XLEN-1:0]  imm_o,
    output logic [3:0]       alu_fn_o,
    output logic             alu_src_imm_o,
    output logic             reg_we_o,
    output logic             mem_re_o,
    output logic             mem_we_o,
    output logic             branch_o,
    output logic             wb_mem_o,
    output logic [XLEN-1:0]  br_target_o
);
    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fn;
    logic [RA_W-1:0]  rd_r;
    logic [RA_W-1:0]  rd_i;
    ctrl_t            ctrl;
    logic [RA_W-1:0]  rd_d;

    idec_fields #(.XLEN(XLEN)) u_fields (
        .instr_i (instr_i),
        .opc_o   (opc),
        .fn_o    (fn),
        .rs1_o   (rs1_o),
        .rs2_o   (rs2_o),
        .rd_r_o  (rd_r),
        .rd_i_o  (rd_i),
        .imm_o   (imm_o)
    );

    idec_ctrl u_ctrl (
        .opc_i  (opc),
        .fn_i   (fn),
        .ctrl_o (ctrl)
    );

    idec_target #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_target (
        .pc_i  (pc_i),
        .off_i (imm_o),
        .tgt_o (br_target_o)
    );

    // destination select: R-type field, I-type field, or none
    always_comb begin
        if (!ctrl.reg_we)        rd_d = '0;
        else if (ctrl.dst_itype) rd_d = rd_i;
        else                     rd_d = rd_r;
    end

    assign rd_o          = rd_d;
    assign alu_fn_o      = ctrl.alu_fn;
    assign alu_src_imm_o = ctrl.src_imm;
    assign reg_we_o      = ctrl.reg_we;
    assign mem_re_o      = ctrl.mem_re;
    assign mem_we_o      = ctrl.mem_we;
    assign branch_o      = ctrl.branch;
    assign wb_mem_o      = ctrl.wb_mem;

    always_comb begin
        if (!$isunknown(instr_i)) begin
            // R2: register ALU words name their destination in bits 15:11
            p_rd_rtype_r2: assert (!(reg_we_o && instr_i[31:26] == OPC_ALU)
                                   || rd_o == instr_i[15:11])
                else $error("register ALU destination misrouted");
            // R4, R5: immediate-form writes name their destination in bits 20:16
            p_rd_itype_r4: assert (!(reg_we_o && instr_i[31:26] != OPC_ALU)
                                   || rd_o == instr_i[20:16])
                else $error("immediate-form destination misrouted");
            // R10: no write means no destination
            p_rd_idle_r10: assert (reg_we_o || rd_o == '0)
                else $error("destination nonzero without write");
            // R7: a branch never takes the immediate as ALU operand
            p_beq_src_r7: assert (!branch_o || !alu_src_imm_o)
                else $error("branch selects immediate operand");
        end
    end

endmodule

// File: tb/insn_decode_tb.sv
module insn_decode_tb;

    function automatic logic [31:0] rt(input int a, input int b, input int d, input logic [3:0] f);
        return {6'b000000, 5'(a), 5'(b), 5'(d), 7'h00, f};
    endfunction

    function automatic logic [31:0] it(input logic [5:0] op, input int a, input int b, input logic [15:0] k);
        return {op, 5'(a), 5'(b), k};
    endfunction

    typedef struct packed {
        logic [31:0] instr;
        logic [31:0] pc;
        logic [4:0]  rd;
        logic [3:0]  fn;
        logic [5:0]  flags;   // {reg_we, src_imm, mem_re, mem_we, branch, wb_mem}
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{rt(3, 4, 5, 4'h0),   32'h0000_0000, 5'd5,  4'h0, 6'b100000, 8'd2},  // R2 add
        '{rt(7, 8, 9, 4'h2),   32'h0000_0010, 5'd9,  4'h2, 6'b100000, 8'd2},  // R2 sub
        '{rt(1, 2, 3, 4'h4),   32'h0000_0020, 5'd3,  4'h4, 6'b100000, 8'd2},  // R2 and
        '{rt(29, 30, 31, 4'h5),32'h0000_0030, 5'd31, 4'h5, 6'b100000, 8'd2},  // R2 or
        '{rt(10, 11, 12, 4'hB),32'h0000_0040, 5'd12, 4'hB, 6'b100000, 8'd2},  // R2 nand
        '{rt(13, 14, 15, 4'hA),32'h0000_0050, 5'd15, 4'hA, 6'b100000, 8'd2},  // R2 nor
        '{rt(16, 17, 18, 4'hC),32'h0000_0060, 5'd18, 4'hC, 6'b100000, 8'd2},  // R2 shl
        '{rt(19, 20, 21, 4'hE),32'h0000_0070, 5'd21, 4'hE, 6'b100000, 8'd2},  // R2 srl
        '{rt(22, 23, 24, 4'hF),32'h0000_0080, 5'd24, 4'hF, 6'b100000, 8'd2},  // R2 sra
        '{{6'b000000, 5'd1, 5'd2, 5'd3, 7'h7F, 4'h4}, 32'h0000_0090, 5'd3, 4'h4, 6'b100000, 8'd2}, // R2 reserved bits
        '{rt(4, 5, 6, 4'h1),   32'h0000_00A0, 5'd0,  4'h0, 6'b000000, 8'd3},  // R3
        '{rt(4, 5, 6, 4'hD),   32'h0000_00B0, 5'd0,  4'h0, 6'b000000, 8'd3},  // R3
        '{it(6'b000011, 2, 6, 16'h8001),  32'h0000_0100, 5'd6,  4'h0, 6'b110000, 8'd4},  // R4
        '{it(6'b100011, 10, 11, 16'h0010),32'h0000_0104, 5'd11, 4'h0, 6'b111001, 8'd5},  // R5
        '{it(6'b101011, 12, 13, 16'hFFFC),32'h0000_0108, 5'd0,  4'h0, 6'b010100, 8'd6},  // R6
        '{it(6'b000100, 1, 2, 16'hFFFF),  32'h0000_0100, 5'd0,  4'h2, 6'b000010, 8'd7},  // R7 self
        '{it(6'b000100, 3, 3, 16'h7FFF),  32'h0000_0000, 5'd0,  4'h2, 6'b000010, 8'd7},  // R7 max fwd
        '{it(6'b000100, 5, 6, 16'h8000),  32'h0004_0000, 5'd0,  4'h2, 6'b000010, 8'd7},  // R7 max back
        '{it(6'b000001, 7, 8, 16'h1234),  32'h0000_0200, 5'd0,  4'h0, 6'b000000, 8'd10}, // R10
        '{it(6'b111111, 31, 31, 16'hFFFF),32'h0000_0204, 5'd0,  4'h0, 6'b000000, 8'd10}, // R10
        '{it(6'b101010, 9, 10, 16'h00FF), 32'h0000_0208, 5'd0,  4'h0, 6'b000000, 8'd10}, // R10
        '{it(6'b000101, 6, 7, 16'hABCD),  32'h0000_020C, 5'd0,  4'h0, 6'b000000, 8'd10}  // R10
    };

    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [31:0] pc;
    logic [4:0]  rs1, rs2, rd;
    logic [31:0] imm, tgt;
    logic [3:0]  fn;
    logic        src, we, re, mw, br, wbm;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    insn_decode u_dut (
        .instr_i       (instr),
        .pc_i          (pc),
        .rs1_o         (rs1),
        .rs2_o         (rs2),
        .rd_o          (rd),
        .imm_o         (imm),
        .alu_fn_o      (fn),
        .alu_src_imm_o (src),
        .reg_we_o      (we),
        .mem_re_o      (re),
        .mem_we_o      (mw),
        .branch_o      (br),
        .wb_mem_o      (wbm),
        .br_target_o   (tgt)
    );

    task automatic check(input string what, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sext(input logic [15:0] k);
        return {{16{k[15]}}, k};
    endfunction

    task automatic apply(input logic [31:0] w, input logic [31:0] p);
        @(negedge clk);
        instr = w;
        pc    = p;
        #2;
    endtask

    initial begin
        instr = '0;
        pc    = '0;
        repeat (3) @(posedge clk);

        // initial word of all zeros is add r0,r0,r0 (R2)
        apply(32'h0, 32'h0);
        check("zero word write", "R2", 32'(we), 32'd1);
        check("zero word rd", "R2", 32'(rd), 32'd0);
        check("zero word target", "R9", tgt, 32'h4);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d", VECS[i].req);
            apply(VECS[i].instr, VECS[i].pc);
            check("rs1", "R1", 32'(rs1), 32'(VECS[i].instr[25:21]));
            check("rs2", "R1", 32'(rs2), 32'(VECS[i].instr[20:16]));
            check("imm", "R8", imm, sext(VECS[i].instr[15:0]));
            check("target", "R9", tgt, VECS[i].pc + 32'd4 + (sext(VECS[i].instr[15:0]) << 2));
            check("rd", tg, 32'(rd), 32'(VECS[i].rd));
            check("alu_fn", tg, 32'(fn), 32'(VECS[i].fn));
            check("flags", tg, 32'({we, src, re, mw, br, wbm}), 32'(VECS[i].flags));
        end

        // R9 branch to itself, and the extremes of the offset range
        apply(it(6'b000100, 1, 2, 16'hFFFF), 32'h0000_0100);
        check("offset -1 targets self", "R9", tgt, 32'h0000_0100);
        apply(it(6'b000100, 1, 2, 16'h7FFF), 32'h0000_0000);
        check("offset +32767", "R9", tgt, 32'h0002_0000);
        apply(it(6'b000100, 1, 2, 16'h8000), 32'h0004_0000);
        check("offset -32768", "R9", tgt, 32'h0002_0004);
        // R9 wrap-around modulo 2^32
        apply(it(6'b000100, 0, 0, 16'h0000), 32'hFFFF_FFFC);
        check("wrap forward", "R9", tgt, 32'h0000_0000);
        apply(it(6'b000100, 0, 0, 16'hFFFE), 32'hFFFF_FFF0);
        check("negative offset", "R9", tgt, 32'hFFFF_FFEC);

        // R8 sign bit clear vs set on a non-branch word
        apply(it(6'b000011, 1, 1, 16'h7FFF), 32'h0);
        check("positive imm", "R8", imm, 32'h0000_7FFF);
        apply(it(6'b101011, 1, 1, 16'h8000), 32'h0);
        check("negative imm", "R8", imm, 32'hFFFF_8000);

        // full opcode sweep: R10 fallback and R11 exclusivity
        for (int op = 0; op < 64; op++) begin
            logic [5:0] o;
            o = 6'(op);
            apply({o, 5'd17, 5'd18, 5'd19, 7'h55, 4'h4}, 32'h0000_1000);
            check("mem read and write exclusive", "R11", 32'(re & mw), 32'd0);
            check("no write with store or branch", "R11", 32'(we & (mw | br)), 32'd0);
            if (o != 6'b000000 && o != 6'b000011 && o != 6'b100011
                && o != 6'b101011 && o != 6'b000100) begin
                check($sformatf("nop flags op %0d", op), "R10", 32'({we, src, re, mw, br, wbm}), 32'd0);
                check($sformatf("nop rd op %0d", op), "R10", 32'(rd), 32'd0);
                check($sformatf("nop fn op %0d", op), "R10", 32'(fn), 32'd0);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule